// File: doc/BRIEF.md
# USB device packet responder

This block sits behind a low-speed USB receiver and decides what a device does with each packet it has just decoded. It classifies the packet from bits of its PID, filters tokens against the device address, and remembers the PID of the last SETUP or OUT token sent to this device. It hands DATA0/DATA1 payloads to the host side through two receive buffers that are used in turn. For each packet it either answers with ACK, answers with NAK, sends the prepared transmit buffer, or stays silent.

The host side owns the far end of both buffers. It frees a receive buffer by pulsing a release strobe, which clears the held length to zero. It queues transmit data by loading a nonzero length. A new device address can be staged at any time and takes effect only when an IN token is answered with data. CRC and endpoint numbers are handled elsewhere.

Top module: `usb_pkt_responder`

## Requirements
- R1: After reset `tx_req` is low, and `dev_addr`, `rx_len`, `rx_buf_base` and the stored token PID are all zero.
- R2: A PID with bit 1 clear is a token. A PID with bits 1 and 0 both set is DATA0/DATA1. A PID with bit 1 set and bit 0 clear is a handshake, which gets no reply and clears the stored token PID.
- R3: For a token, bits 6:0 of the byte after the PID are compared with `dev_addr`, and bit 7 is ignored. On a mismatch there is no reply and the stored token PID is cleared.
- R4: An IN token (PID 0x69) addressed to the device gets NAK if the transmit length is zero or if `rx_len` is nonzero.
- R5: In the remaining IN case the reply is the transmit buffer with `tx_count` equal to the loaded length. The transmit length then becomes zero and `dev_addr` takes the value of `host_new_addr`.
- R6: A token other than IN addressed to the device stores its PID and gets no reply.
- R7: DATA0/DATA1 that arrives while the stored token PID is zero gets no reply and changes nothing else.
- R8: DATA0/DATA1 that arrives with a nonzero stored PID while `rx_len` is nonzero gets NAK and changes no state.
- R9: Otherwise DATA0/DATA1 gets ACK. `rx_len` takes `pkt_len`, `rx_token` takes the stored PID, and `rx_buf_base` switches between 0 and BUF_BYTES.
- R10: Each reply appears as a single-cycle `tx_req` in the cycle after `pkt_valid`. `tx_src` is coded 0 = ACK, 1 = NAK, 2 = transmit buffer. `tx_count` is 1 for ACK or NAK.
- R11: `host_rx_release` clears `rx_len`, and `host_tx_load` sets the transmit length to `host_tx_len`. If a packet updates the same length in the same cycle, the packet's update wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | One-cycle strobe: a decoded packet is presented |
| pkt_pid | input | 8 | PID byte of the packet |
| pkt_byte1 | input | 8 | Byte following the PID |
| pkt_len | input | LEN_W | Packet length in bytes |
| host_rx_release | input | 1 | Host frees the held receive buffer |
| host_tx_load | input | 1 | Host loads a transmit length |
| host_tx_len | input | LEN_W | Transmit length to load |
| host_new_addr | input | ADDR_W | Staged device address |
| tx_req | output | 1 | One-cycle reply request |
| tx_src | output | 2 | Reply source: 0 ACK, 1 NAK, 2 transmit buffer |
| tx_count | output | LEN_W | Bytes to send for the reply |
| rx_len | output | LEN_W | Length of the held received packet, 0 when free |
| rx_token | output | 8 | Token PID that preceded the held packet |
| rx_buf_base | output | LEN_W | Byte offset of the buffer that receives the next packet |
| dev_addr | output | ADDR_W | Active device address |

## Verification
Every result of a packet is due one clock edge after the `pkt_valid` edge. This covers the reply strobe, its source and count, and the updates to the address, length, token and buffer base. Host strobes also take effect at that same edge. The bench drives each stimulus on a falling edge and waits for exactly one rising edge. It then checks every output against its own model on the following falling edge, before the next stimulus is driven. Because the next check falls in the following step, it also confirms that `tx_req` has dropped again.

// File: rtl/usbr_pkg.sv
package usbr_pkg;
   typedef enum logic [1:0] {
      SRC_ACK  = 2'd0,
      SRC_NAK  = 2'd1,
      SRC_DATA = 2'd2
   } tx_src_e;

   localparam logic [7:0] PID_IN = 8'h69;
endpackage

// File: rtl/usbr_classify.sv
module usbr_classify #(
   parameter int ADDR_W = 7
) (
   input  logic [7:0]        pid,
   input  logic [7:0]        byte1,
   input  logic [ADDR_W-1:0] dev_addr,
   output logic              is_token,
   output logic              is_data,
   output logic              is_in,
   output logic              addr_hit
);
   import usbr_pkg::*;

   always_comb begin
      is_token = ~pid[1];
      is_data  = pid[1] & pid[0];
      is_in    = (pid == PID_IN);
      addr_hit = (byte1[6:0] == 7'(dev_addr));
   end
endmodule

// File: rtl/usbr_token_track.sv
module usbr_token_track (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       upd,
   input  logic [7:0] nxt,
   output logic [7:0] stored
);
   always_ff @(posedge clk) begin
      if (!rst_n)   stored <= '0;
      else if (upd) stored <= nxt;
   end
endmodule

// File: rtl/usbr_bufctl.sv
module usbr_bufctl #(
   parameter int BUF_BYTES = 12,
   parameter int LEN_W     = 4,
   parameter int ADDR_W    = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [LEN_W-1:0]  acc_len,
   input  logic [7:0]        acc_tok,
   input  logic              send_data,
   input  logic [ADDR_W-1:0] new_addr,
   input  logic              rx_release,
   input  logic              tx_load,
   input  logic [LEN_W-1:0]  tx_load_len,
   input  logic              tx_req,
   input  logic [1:0]        tx_src,
   output logic [LEN_W-1:0]  rx_len,
   output logic [7:0]        rx_token,
   output logic              buf_sel,
   output logic [LEN_W-1:0]  tx_len,
   output logic [ADDR_W-1:0] dev_addr
);
   import usbr_pkg::*;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_len   <= '0;
         rx_token <= '0;
         buf_sel  <= 1'b0;
      end else if (accept) begin
         rx_len   <= acc_len;
         rx_token <= acc_tok;
         buf_sel  <= ~buf_sel;
      end else if (rx_release) begin
         rx_len   <= '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_len   <= '0;
         dev_addr <= '0;
      end else if (send_data) begin
         tx_len   <= '0;
         dev_addr <= new_addr;
      end else if (tx_load) begin
         tx_len   <= tx_load_len;
      end
   end

   // R9: a buffer only fills when the packet is acknowledged
   a_r9_fill_acked: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_len != '0 && $past(rx_len) == '0) |-> (tx_req && tx_src == SRC_ACK));
   // R9: the buffer base only moves on an ACK
   a_r9_flip_acked: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_sel != $past(buf_sel)) |-> (tx_req && tx_src == SRC_ACK));
   // R5: the address only changes when data is sent
   a_r5_addr_on_data: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_addr != $past(dev_addr)) |-> (tx_req && tx_src == SRC_DATA));
   // R5: sending data leaves the transmit buffer free
   a_r5_tx_freed: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_req && tx_src == SRC_DATA) |-> (tx_len == '0));
endmodule

// File: rtl/usb_pkt_responder.sv
module usb_pkt_responder #(
   parameter int BUF_BYTES = 12,
   parameter int LEN_W     = $clog2(BUF_BYTES + 1),
   parameter int ADDR_W    = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pkt_valid,
   input  logic [7:0]        pkt_pid,
   input  logic [7:0]        pkt_byte1,
   input  logic [LEN_W-1:0]  pkt_len,
   input  logic              host_rx_release,
   input  logic              host_tx_load,
   input  logic [LEN_W-1:0]  host_tx_len,
   input  logic [ADDR_W-1:0] host_new_addr,
   output logic              tx_req,
   output logic [1:0]        tx_src,
   output logic [LEN_W-1:0]  tx_count,
   output logic [LEN_W-1:0]  rx_len,
   output logic [7:0]        rx_token,
   output logic [LEN_W-1:0]  rx_buf_base,
   output logic [ADDR_W-1:0] dev_addr
);
   import usbr_pkg::*;

   localparam int MIN_LEN_W = $clog2(BUF_BYTES + 1);

   if (BUF_BYTES < 3) begin : g_bad_buf
      $error("BUF_BYTES must hold at least a PID and CRC");
   end
   if (LEN_W < MIN_LEN_W) begin : g_bad_len
      $error("LEN_W too narrow for BUF_BYTES");
   end
   if (ADDR_W < 1 || ADDR_W > 7) begin : g_bad_addr
      $error("ADDR_W must be 1 to 7");
   end

   logic is_token, is_data, is_in, addr_hit;
   logic [7:0] stored_pid;
   logic [LEN_W-1:0] tx_len;
   logic buf_sel;

   logic ign, tok_upd, accept, send_data, rep_valid;
   logic [7:0] tok_nxt;
   tx_src_e rep_src;
   logic [LEN_W-1:0] rep_cnt;

   usbr_classify #(.ADDR_W(ADDR_W)) classify_i (
      .pid(pkt_pid), .byte1(pkt_byte1), .dev_addr(dev_addr),
      .is_token(is_token), .is_data(is_data), .is_in(is_in), .addr_hit(addr_hit)
   );

   usbr_token_track track_i (
      .clk(clk), .rst_n(rst_n), .upd(tok_upd), .nxt(tok_nxt), .stored(stored_pid)
   );

   usbr_bufctl #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) bufctl_i (
      .clk(clk), .rst_n(rst_n),
      .accept(accept), .acc_len(pkt_len), .acc_tok(stored_pid),
      .send_data(send_data), .new_addr(host_new_addr),
      .rx_release(host_rx_release), .tx_load(host_tx_load), .tx_load_len(host_tx_len),
      .tx_req(tx_req), .tx_src(tx_src),
      .rx_len(rx_len), .rx_token(rx_token), .buf_sel(buf_sel),
      .tx_len(tx_len), .dev_addr(dev_addr)
   );

   always_comb begin
      ign       = 1'b0;
      tok_upd   = 1'b0;
      tok_nxt   = '0;
      accept    = 1'b0;
      send_data = 1'b0;
      rep_valid = 1'b0;
      rep_src   = SRC_ACK;
      rep_cnt   = LEN_W'(1);
      if (pkt_valid) begin
         if (is_token) begin
            if (!addr_hit) begin
               ign = 1'b1;
            end else if (is_in) begin
               rep_valid = 1'b1;
               if (tx_len == '0 || rx_len != '0) begin
                  rep_src = SRC_NAK;
               end else begin
                  rep_src   = SRC_DATA;
                  rep_cnt   = tx_len;
                  send_data = 1'b1;
               end
            end else begin
               tok_upd = 1'b1;
               tok_nxt = pkt_pid;
            end
         end else if (!is_data || stored_pid == '0) begin
            ign = 1'b1;
         end else if (rx_len != '0) begin
            rep_valid = 1'b1;
            rep_src   = SRC_NAK;
         end else begin
            accept    = 1'b1;
            rep_valid = 1'b1;
            rep_src   = SRC_ACK;
         end
      end
      if (ign) begin
         tok_upd = 1'b1;
         tok_nxt = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_req   <= 1'b0;
         tx_src   <= SRC_ACK;
         tx_count <= '0;
      end else begin
         tx_req   <= rep_valid;
         tx_src   <= rep_src;
         tx_count <= rep_cnt;
      end
   end

   assign rx_buf_base = buf_sel ? LEN_W'(BUF_BYTES) : '0;

   // R10: a reply is only requested in the cycle after a packet
   a_r10_req_after_pkt: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req |-> $past(pkt_valid));
   // R10: only the three defined reply sources occur
   a_r10_src_legal: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req |-> (tx_src != 2'd3));
   // R5: a data reply never carries zero bytes
   a_r5_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_req && tx_src == SRC_DATA) |-> (tx_count != '0));
endmodule

// File: tb/usb_pkt_responder_tb_top.sv
module usb_pkt_responder_tb_top;
   localparam int BUF = 12;
   localparam int LW  = 4;
   localparam int AW  = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pkt_valid = 1'b0;
   logic [7:0] pkt_pid = '0, pkt_byte1 = '0;
   logic [LW-1:0] pkt_len = '0;
   logic host_rx_release = 1'b0, host_tx_load = 1'b0;
   logic [LW-1:0] host_tx_len = '0;
   logic [AW-1:0] host_new_addr = '0;
   logic tx_req;
   logic [1:0] tx_src;
   logic [LW-1:0] tx_count, rx_len, rx_buf_base;
   logic [7:0] rx_token;
   logic [AW-1:0] dev_addr;

   usb_pkt_responder #(.BUF_BYTES(BUF), .LEN_W(LW), .ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_pid(pkt_pid),
      .pkt_byte1(pkt_byte1), .pkt_len(pkt_len), .host_rx_release(host_rx_release),
      .host_tx_load(host_tx_load), .host_tx_len(host_tx_len), .host_new_addr(host_new_addr),
      .tx_req(tx_req), .tx_src(tx_src), .tx_count(tx_count), .rx_len(rx_len),
      .rx_token(rx_token), .rx_buf_base(rx_buf_base), .dev_addr(dev_addr)
   );

   always #5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   int m_addr = 0, m_rx = 0, m_rtok = 0, m_sel = 0, m_tx = 0, m_tok = 0;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R10 watchdog actual 1 expected 0");
      finish_run();
   end

   function automatic int base_of(input int sel);
      return sel ? BUF : 0;
   endfunction

   task automatic step(input bit pv, input logic [7:0] pid, input logic [7:0] b1,
                       input int len, input bit rel, input bit ld, input int ldlen,
                       input int na);
      bit er, ign, acc, snd, tok_store;
      int es, ec;
      string tag;
      er = 0; ign = 0; acc = 0; snd = 0; tok_store = 0;
      es = 0; ec = 1; tag = "R11";
      if (pv) begin
         if (!pid[1]) begin
            if (int'(b1[6:0]) != m_addr) begin ign = 1; tag = "R3"; end
            else if (pid == 8'h69) begin
               er = 1;
               if (m_tx == 0 || m_rx != 0) begin es = 1; tag = "R4"; end
               else begin es = 2; ec = m_tx; snd = 1; tag = "R5"; end
            end else begin tok_store = 1; tag = "R6"; end
         end else if (!pid[0]) begin ign = 1; tag = "R2"; end
         else if (m_tok == 0) begin ign = 1; tag = "R7"; end
         else if (m_rx != 0) begin er = 1; es = 1; tag = "R8"; end
         else begin er = 1; es = 0; acc = 1; tag = "R9"; end
      end
      if (acc) begin m_rx = len; m_rtok = m_tok; m_sel ^= 1; end
      else if (rel) m_rx = 0;
      if (snd) begin m_tx = 0; m_addr = na; end
      else if (ld) m_tx = ldlen;
      if (ign) m_tok = 0;
      else if (tok_store) m_tok = pid;

      pkt_valid = pv; pkt_pid = pid; pkt_byte1 = b1; pkt_len = LW'(len);
      host_rx_release = rel; host_tx_load = ld; host_tx_len = LW'(ldlen);
      host_new_addr = AW'(na);
      @(posedge clk);
      @(negedge clk);
      pkt_valid = 0; host_rx_release = 0; host_tx_load = 0;
      chk({"R10 ", tag, " tx_req"}, tx_req, er);
      if (er) begin
         chk({"R10 ", tag, " tx_src"}, tx_src, es);
         chk({"R10 ", tag, " tx_count"}, tx_count, ec);
      end
      chk({tag, " dev_addr"}, dev_addr, m_addr);
      chk({tag, " rx_len"}, rx_len, m_rx);
      if (m_rx != 0) chk({tag, " rx_token"}, rx_token, m_rtok);
      chk({tag, " rx_buf_base"}, rx_buf_base, base_of(m_sel));
   endtask

   task automatic idle();
      step(0, 8'h00, 8'h00, 0, 0, 0, 0, 0);
   endtask

   logic [7:0] pids [8] = '{8'h69, 8'hE1, 8'h2D, 8'hC3, 8'h4B, 8'hD2, 8'h5A, 8'h1E};

   initial begin
      void'($urandom(32'd5150));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: reset state
      chk("R1 tx_req", tx_req, 0);
      chk("R1 dev_addr", dev_addr, 0);
      chk("R1 rx_len", rx_len, 0);
      chk("R1 rx_buf_base", rx_buf_base, 0);
      step(1, 8'hC3, 8'h00, 5, 0, 0, 0, 0);          // R1/R7: stored PID starts at zero
      // R4: IN with nothing queued
      step(1, 8'h69, 8'h00, 3, 0, 0, 0, 0);
      // R11: host queues 5 bytes, stages address 9
      step(0, 8'h00, 8'h00, 0, 0, 1, 5, 9);
      // R5: IN answered with data, address switches
      step(1, 8'h69, 8'h80, 3, 0, 0, 0, 9);
      // R3: old address now mismatches
      step(1, 8'hE1, 8'h00, 3, 0, 0, 0, 9);
      step(1, 8'hC3, 8'h00, 5, 0, 0, 0, 9);          // R7
      step(1, 8'h2D, 8'h89, 3, 0, 0, 0, 9);          // R6 with bit 7 set (R3)
      step(1, 8'hC3, 8'h00, 11, 0, 0, 0, 9);         // R9
      step(1, 8'hE1, 8'h09, 3, 0, 0, 0, 9);          // R6
      step(1, 8'h4B, 8'h00, 4, 0, 0, 0, 9);          // R8
      step(0, 8'h00, 8'h00, 0, 0, 1, 3, 2);          // R11 load
      step(1, 8'h69, 8'h09, 3, 0, 0, 0, 2);          // R4 receive buffer busy
      step(1, 8'hD2, 8'h00, 3, 1, 0, 0, 2);          // R2 handshake clears token, R11 release
      step(1, 8'h4B, 8'h00, 6, 0, 0, 0, 2);          // R7
      step(1, 8'hE1, 8'h09, 3, 0, 0, 0, 2);          // R6
      step(1, 8'h4B, 8'h00, 6, 1, 0, 0, 2);          // R9 and R11 precedence
      step(1, 8'h69, 8'h09, 3, 1, 1, 7, 2);          // R4 busy, release/load apply
      step(1, 8'h69, 8'h09, 3, 0, 1, 4, 2);          // R5/R11 packet clear beats load
      idle();
      for (int i = 0; i < 4000; i++) begin
         bit pv;
         logic [7:0] pid, b1;
         pv  = ($urandom % 3) != 0;
         pid = pids[$urandom % 8];
         b1  = (($urandom % 4) != 0) ? {1'($urandom), 7'(m_addr)} : 8'($urandom);
         step(pv, pid, b1, 3 + ($urandom % 10), ($urandom % 6) == 0,
              ($urandom % 5) == 0, 1 + ($urandom % 12), $urandom % 4);
      end
      finish_run();
   end
endmodule